// File: doc/BRIEF.md
# Precision Time-of-Day Counter with Second Pulse

This block keeps the time of day for precision time protocol use. It counts seconds and nanoseconds from a single reference clock. Each cycle it adds a programmed step, given in 1/256-nanosecond units, to a sub-nanosecond accumulator. The accumulator wraps at one second and carries into a 48-bit seconds counter. The current time is always on the outputs in the standard protocol layout: 48 bits of seconds and 32 bits of nanoseconds.

Software sets the time with a single load. It tunes the rate by rewriting the step. It can also request a one-shot signed correction in nanoseconds and then poll a completion flag until the correction has been applied. A second-pulse output rises on the same cycle that the seconds count advances through a nanosecond rollover, so the pulse can be used to measure clock accuracy against an external reference. The pulse stays high for a configurable number of reference cycles.

Top module: `ptp_tod_clock`

## Requirements
- R1: While reset is asserted and right after it is released, the outputs are: seconds 0, nanoseconds 0, pulse low and completion flag high. The step register holds the reset step of 1280 (5 ns).
- R2: On each clock edge with no load and no pending correction, the accumulator advances by the step, counted in units of 1/256 ns. The nanoseconds output is the accumulator divided by 256, with the remainder dropped.
- R3: The nanoseconds output never reaches 1,000,000,000. When the accumulator reaches 256,000,000,000, that amount is subtracted from it and the seconds count advances by one on the same edge.
- R4: A step write goes into effect on the following edge. The edge on which the write is taken still advances the time by the old step.
- R5: A load sets seconds and nanoseconds on one edge and clears the fraction bits. No step is added on that edge. If a correction is pending at the same edge, the load takes precedence and the correction is applied on the next edge without a load.
- R6: A correction request carries a two's-complement nanosecond offset whose magnitude is below 10^9. It is applied once, on the next edge without a load, together with that edge's normal step. A result below zero borrows one second, and a result of one second or more carries one second.
- R7: The completion flag goes low on the edge that takes a correction request. It goes high on the edge that applies the correction.
- R8: The pulse output rises on the same edge that the seconds count advances through a rollover, whether the rollover comes from the step or from a correction carry. It does not rise on a load or on a borrow.
- R9: After a rollover, the pulse stays high for max(pulse_len, 1) cycles and then returns low. A new rollover restarts the count.
- R10: The seconds count wraps from 2^48-1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_we | input | 1 | Write strobe for the step register |
| step_val | input | 32 | New step, in 1/256 ns units |
| load_we | input | 1 | Time load strobe |
| load_sec | input | 48 | Seconds value to load |
| load_ns | input | 32 | Nanoseconds value to load (below 10^9) |
| corr_req | input | 1 | One-shot correction request |
| corr_ns | input | 32 | Signed correction offset in nanoseconds |
| pulse_len | input | 24 | Pulse width in reference cycles (0 is treated as 1) |
| corr_done | output | 1 | Correction completion flag |
| tod_sec | output | 48 | Current seconds |
| tod_ns | output | 32 | Current nanoseconds |
| sec_pulse | output | 1 | Once-per-second pulse |

## Verification
The bench loads times a few nanoseconds before a second boundary so that rollovers happen within a few cycles. A design that compared against the wrong wrap limit would show a nanoseconds value of one billion, or would advance the seconds one edge late. Corrections are driven both across the boundary forward and across it backward. A design with a faulty borrow would leave the seconds count unchanged, or would raise the pulse on a backward crossing. A load is placed on the edge where a pending correction would be applied, to catch a design that drops or doubles the correction. A step rewrite is combined with a load to show whether the new step is used one edge early. A separate case sets the seconds count to its maximum value to check the 48-bit wrap.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
    localparam int FRAC_W = 8;
    localparam longint unsigned NS_PER_SEC = 64'd1_000_000_000;
    localparam longint unsigned SUBNS_PER_SEC = NS_PER_SEC << FRAC_W;
endpackage

// File: rtl/ptp_tod_step.sv
// Normal advance path: the step minus the modulo is precomputed, so the wrap
// decision is the sign of a second adder running in parallel with the plain sum.
module ptp_tod_step #(
    parameter int ACC_W = 40,
    parameter int INC_W = 32
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [INC_W-1:0] inc_i,
    input  logic [ACC_W:0]   pre_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             wrap_o
);
    logic [ACC_W-1:0] sum;
    logic [ACC_W:0]   alt;

    always_comb begin
        sum    = acc_i + ACC_W'(inc_i);
        alt    = {1'b0, acc_i} + pre_i;
        wrap_o = ~alt[ACC_W];
        acc_o  = wrap_o ? alt[ACC_W-1:0] : sum;
    end
endmodule

// File: rtl/ptp_tod_adjust.sv
// Correction path: adds step plus a signed nanosecond offset, then folds the
// result back into one second with a borrow or a carry.
module ptp_tod_adjust #(
    parameter int SEC_W = 48,
    parameter int ACC_W = 40,
    parameter int INC_W = 32,
    parameter int ADJ_W = 32,
    parameter int FRAC_W = 8,
    parameter logic [ACC_W-1:0] MOD = '0
) (
    input  logic [ACC_W-1:0]        acc_i,
    input  logic [INC_W-1:0]        inc_i,
    input  logic signed [ADJ_W-1:0] off_i,
    input  logic [SEC_W-1:0]        sec_i,
    output logic [ACC_W-1:0]        acc_o,
    output logic [SEC_W-1:0]        sec_o,
    output logic                    carry_o
);
    localparam int BASE_W = (ACC_W > ADJ_W + FRAC_W) ? ACC_W : ADJ_W + FRAC_W;
    localparam int W = BASE_W + 3;

    logic signed [W-1:0] acc_x, inc_x, off_x, mod_x, tot;

    always_comb begin
        acc_x   = $signed({{(W-ACC_W){1'b0}}, acc_i});
        inc_x   = $signed({{(W-INC_W){1'b0}}, inc_i});
        off_x   = W'(off_i) <<< FRAC_W;
        mod_x   = $signed({{(W-ACC_W){1'b0}}, MOD});
        tot     = acc_x + inc_x + off_x;
        acc_o   = ACC_W'(tot);
        sec_o   = sec_i;
        carry_o = 1'b0;
        if (tot[W-1]) begin
            acc_o = ACC_W'(tot + mod_x);
            sec_o = sec_i - SEC_W'(1);
        end else if (tot >= mod_x) begin
            acc_o   = ACC_W'(tot - mod_x);
            sec_o   = sec_i + SEC_W'(1);
            carry_o = 1'b1;
        end
    end
endmodule

// File: rtl/ptp_tod_pps.sv
module ptp_tod_pps #(
    parameter int PPS_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             roll_i,
    input  logic [PPS_W-1:0] len_i,
    output logic             pps_o
);
    logic [PPS_W-1:0] cnt_d, cnt_q;
    logic             pps_d, pps_q;

    always_comb begin
        if (roll_i) begin
            pps_d = 1'b1;
            cnt_d = (len_i == '0) ? '0 : len_i - PPS_W'(1);
        end else begin
            pps_d = (cnt_q != '0);
            cnt_d = (cnt_q != '0) ? cnt_q - PPS_W'(1) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pps_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            pps_q <= pps_d;
        end
    end

    assign pps_o = pps_q;
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
    import ptp_tod_pkg::*;
#(
    parameter int SEC_W = 48,
    parameter int NS_W = 32,
    parameter int INC_W = 32,
    parameter int ADJ_W = 32,
    parameter int PPS_W = 24,
    parameter int unsigned STEP_RESET = 1280
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_we,
    input  logic [INC_W-1:0] step_val,
    input  logic             load_we,
    input  logic [SEC_W-1:0] load_sec,
    input  logic [NS_W-1:0]  load_ns,
    input  logic             corr_req,
    input  logic [ADJ_W-1:0] corr_ns,
    input  logic [PPS_W-1:0] pulse_len,
    output logic             corr_done,
    output logic [SEC_W-1:0] tod_sec,
    output logic [NS_W-1:0]  tod_ns,
    output logic             sec_pulse
);
    localparam int ACC_W = NS_W + FRAC_W;
    localparam logic [ACC_W-1:0] MOD = ACC_W'(SUBNS_PER_SEC);
    localparam logic [ACC_W:0] PRE_RESET = (ACC_W+1)'(STEP_RESET) - {1'b0, MOD};

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [ACC_W-1:0] acc;
        logic [INC_W-1:0] inc;
        logic [ACC_W:0]   pre;
        logic             pend;
        logic [ADJ_W-1:0] off;
        logic             done;
    } tod_state_t;

    tod_state_t st_d, st_q;

    logic [ACC_W-1:0] step_acc, adj_acc;
    logic             step_wrap, adj_carry;
    logic [SEC_W-1:0] adj_sec;
    logic             apply, roll;

    ptp_tod_step #(.ACC_W(ACC_W), .INC_W(INC_W)) step_i (
        .acc_i  (st_q.acc),
        .inc_i  (st_q.inc),
        .pre_i  (st_q.pre),
        .acc_o  (step_acc),
        .wrap_o (step_wrap)
    );

    ptp_tod_adjust #(
        .SEC_W(SEC_W), .ACC_W(ACC_W), .INC_W(INC_W),
        .ADJ_W(ADJ_W), .FRAC_W(FRAC_W), .MOD(MOD)
    ) adjust_i (
        .acc_i   (st_q.acc),
        .inc_i   (st_q.inc),
        .off_i   ($signed(st_q.off)),
        .sec_i   (st_q.sec),
        .acc_o   (adj_acc),
        .sec_o   (adj_sec),
        .carry_o (adj_carry)
    );

    ptp_tod_pps #(.PPS_W(PPS_W)) pps_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .roll_i (roll),
        .len_i  (pulse_len),
        .pps_o  (sec_pulse)
    );

    always_comb begin
        st_d  = st_q;
        roll  = 1'b0;
        apply = st_q.pend && !load_we;

        if (load_we) begin
            st_d.sec = load_sec;
            st_d.acc = {load_ns, {FRAC_W{1'b0}}};
        end else if (apply) begin
            st_d.sec = adj_sec;
            st_d.acc = adj_acc;
            roll     = adj_carry;
        end else begin
            st_d.sec = st_q.sec + SEC_W'(step_wrap);
            st_d.acc = step_acc;
            roll     = step_wrap;
        end

        if (step_we) begin
            st_d.inc = step_val;
            st_d.pre = (ACC_W+1)'(step_val) - {1'b0, MOD};
        end

        if (corr_req) begin
            st_d.pend = 1'b1;
            st_d.off  = corr_ns;
            st_d.done = 1'b0;
        end else if (apply) begin
            st_d.pend = 1'b0;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sec  <= '0;
            st_q.acc  <= '0;
            st_q.inc  <= INC_W'(STEP_RESET);
            st_q.pre  <= PRE_RESET;
            st_q.pend <= 1'b0;
            st_q.off  <= '0;
            st_q.done <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tod_sec   = st_q.sec;
    assign tod_ns    = st_q.acc[ACC_W-1:FRAC_W];
    assign corr_done = st_q.done;
endmodule

// File: rtl/ptp_tod_clock_chk.sv
module ptp_tod_clock_chk
    import ptp_tod_pkg::*;
#(
    parameter int SEC_W = 48,
    parameter int NS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_we,
    input logic [SEC_W-1:0] load_sec,
    input logic [NS_W-1:0]  load_ns,
    input logic             corr_req,
    input logic             corr_done,
    input logic [SEC_W-1:0] tod_sec,
    input logic [NS_W-1:0]  tod_ns,
    input logic             sec_pulse
);
    p_ns_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tod_ns < NS_W'(NS_PER_SEC));

    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (tod_sec == $past(load_sec)) && (tod_ns == $past(load_ns)));

    p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        corr_req |=> !corr_done);

    p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(corr_req) && !corr_req && !load_we) |=> corr_done);

    p_pulse_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_pulse) |-> (tod_sec == SEC_W'($past(tod_sec) + SEC_W'(1))));
endmodule

bind ptp_tod_clock ptp_tod_clock_chk #(.SEC_W(SEC_W), .NS_W(NS_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_we   (load_we),
    .load_sec  (load_sec),
    .load_ns   (load_ns),
    .corr_req  (corr_req),
    .corr_done (corr_done),
    .tod_sec   (tod_sec),
    .tod_ns    (tod_ns),
    .sec_pulse (sec_pulse)
);

// File: tb/ptp_tod_clock_tb_top.sv
`timescale 1ns/1ps
module ptp_tod_clock_tb_top;
    localparam longint MODV = 64'd256_000_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_we = 1'b0;
    logic [31:0] step_val = '0;
    logic        load_we = 1'b0;
    logic [47:0] load_sec = '0;
    logic [31:0] load_ns = '0;
    logic        corr_req = 1'b0;
    logic [31:0] corr_ns = '0;
    logic [23:0] pulse_len = 24'd3;
    logic        corr_done;
    logic [47:0] tod_sec;
    logic [31:0] tod_ns;
    logic        sec_pulse;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ptp_tod_clock dut_i (
        .clk(clk), .rst_n(rst_n), .step_we(step_we), .step_val(step_val),
        .load_we(load_we), .load_sec(load_sec), .load_ns(load_ns),
        .corr_req(corr_req), .corr_ns(corr_ns), .pulse_len(pulse_len),
        .corr_done(corr_done), .tod_sec(tod_sec), .tod_ns(tod_ns),
        .sec_pulse(sec_pulse)
    );

    // behavioural reference model
    logic [47:0] m_sec = '0;
    longint      m_acc = 0;
    longint      m_inc = 1280;
    bit          m_pend = 0;
    longint      m_off = 0;
    bit          m_done = 1;
    bit          m_pps = 0;
    longint      m_cnt = 0;
    longint      t;
    bit          roll, apply;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sec = '0; m_acc = 0; m_inc = 1280; m_pend = 0;
            m_off = 0; m_done = 1; m_pps = 0; m_cnt = 0;
        end else begin
            roll  = 0;
            apply = m_pend && !load_we;
            if (load_we) begin
                m_sec = load_sec;
                m_acc = longint'(load_ns) * 256;
            end else begin
                t = m_acc + m_inc + (apply ? m_off * 256 : 0);
                if (t < 0) begin
                    t = t + MODV; m_sec = m_sec - 48'd1;
                end else if (t >= MODV) begin
                    t = t - MODV; m_sec = m_sec + 48'd1; roll = 1;
                end
                m_acc = t;
            end
            if (step_we) m_inc = longint'(step_val);
            if (corr_req) begin
                m_pend = 1; m_off = longint'($signed(corr_ns)); m_done = 0;
            end else if (apply) begin
                m_pend = 0; m_done = 1;
            end
            if (roll) begin
                m_pps = 1;
                m_cnt = (pulse_len == 0) ? 0 : longint'(pulse_len) - 1;
            end else begin
                m_pps = (m_cnt != 0);
                if (m_cnt != 0) m_cnt = m_cnt - 1;
            end
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 R3 tod_ns vs model", longint'(tod_ns), m_acc / 256);
            check("R3 R6 R10 tod_sec vs model", longint'(tod_sec), longint'(m_sec));
            check("R8 R9 sec_pulse vs model", longint'(sec_pulse), longint'(m_pps));
            check("R7 corr_done vs model", longint'(corr_done), longint'(m_done));
        end
    end

    task automatic do_load(input logic [47:0] s, input logic [31:0] n);
        load_sec = s; load_ns = n; load_we = 1'b1;
        @(negedge clk);
        load_we = 1'b0;
    endtask

    task automatic do_corr(input logic [31:0] off);
        corr_ns = off; corr_req = 1'b1;
        @(negedge clk);
        corr_req = 1'b0;
    endtask

    task automatic do_step(input logic [31:0] v);
        step_val = v; step_we = 1'b1;
        @(negedge clk);
        step_we = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        longint ns0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 sec at reset", longint'(tod_sec), 0);
        check("R1 ns at reset", longint'(tod_ns), 0);
        check("R1 pulse at reset", longint'(sec_pulse), 0);
        check("R1 done at reset", longint'(corr_done), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first step uses reset step", longint'(tod_ns), 5);
        ns0 = longint'(tod_ns);
        @(negedge clk);
        check("R2 advance by 5 ns", longint'(tod_ns), ns0 + 5);

        // R3 R8 R9 rollover and pulse width
        do_load(48'd10, 32'd999_999_990);
        check("R5 load sec", longint'(tod_sec), 10);
        check("R5 load ns", longint'(tod_ns), 999_999_990);
        @(negedge clk);
        check("R3 below boundary", longint'(tod_ns), 999_999_995);
        @(negedge clk);
        check("R3 wrap ns", longint'(tod_ns), 0);
        check("R3 carry sec", longint'(tod_sec), 11);
        check("R8 pulse rises with carry", longint'(sec_pulse), 1);
        @(negedge clk);
        check("R9 pulse cycle 2", longint'(sec_pulse), 1);
        @(negedge clk);
        check("R9 pulse cycle 3", longint'(sec_pulse), 1);
        @(negedge clk);
        check("R9 pulse ends", longint'(sec_pulse), 0);

        // R4 step rewrite together with a load
        step_val = 32'd1000; step_we = 1'b1;
        do_load(48'd40, 32'd100);
        step_we = 1'b0;
        check("R5 load with step write", longint'(tod_ns), 100);
        @(negedge clk);
        check("R4 new step in effect", longint'(tod_ns), 103);
        @(negedge clk);
        check("R4 fraction kept", longint'(tod_ns), 107);
        do_step(32'd1280);
        check("R4 write edge uses old step", longint'(tod_ns), 111);

        // R6 R7 R8 forward correction across the boundary
        do_load(48'd20, 32'd999_999_000);
        do_corr(32'd2000);
        check("R7 done low after request", longint'(corr_done), 0);
        check("R6 no offset on request edge", longint'(tod_ns), 999_999_005);
        @(negedge clk);
        check("R6 forward ns", longint'(tod_ns), 1010);
        check("R6 forward sec", longint'(tod_sec), 21);
        check("R8 pulse on correction carry", longint'(sec_pulse), 1);
        check("R7 done high after apply", longint'(corr_done), 1);
        repeat (5) @(negedge clk);

        // R6 R8 backward correction with borrow
        do_load(48'd30, 32'd100);
        do_corr(-32'sd5000);
        @(negedge clk);
        check("R6 borrow ns", longint'(tod_ns), 999_995_110);
        check("R6 borrow sec", longint'(tod_sec), 29);
        check("R8 no pulse on borrow", longint'(sec_pulse), 0);

        // R5 load takes precedence over a pending correction
        do_corr(32'd1000);
        do_load(48'd50, 32'd500);
        check("R5 load wins ns", longint'(tod_ns), 500);
        check("R5 correction still pending", longint'(corr_done), 0);
        @(negedge clk);
        check("R5 deferred correction applied", longint'(tod_ns), 1505);
        check("R7 done after deferred apply", longint'(corr_done), 1);

        // R10 seconds wrap and R9 zero length
        pulse_len = 24'd0;
        do_load(48'hFFFF_FFFF_FFFF, 32'd999_999_995);
        @(negedge clk);
        check("R10 seconds wrap", longint'(tod_sec), 0);
        check("R9 pulse len 0 high", longint'(sec_pulse), 1);
        @(negedge clk);
        check("R9 pulse len 0 one cycle", longint'(sec_pulse), 0);

        repeat (20) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule